// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block is the per-processor end of an interrupt fabric. It keeps one pending-interrupt slot and decides, for each interrupt that a source controller presents, whether the processor should see it. The decision uses the processor's current priority threshold and the priority of whatever is already waiting. A lower number means a more urgent interrupt. An interrupt that loses, whether it is refused on arrival or pushed out of the slot by a more urgent one, is handed back to its source on a reject strobe that carries its source number. The source can then present it again later.

Software drives the block with four commands, one per cycle: accept, set threshold, set inter-processor request level, and end-of-interrupt. A 32-bit presentation word packs the threshold into bits 31:24 and the pending source number into bits 23:0. Accept returns this word and frees the slot. A processor-to-processor interrupt is made by writing a request level below the threshold. It then takes the slot under the fixed source number 2. When the threshold is relaxed, or after an end-of-interrupt, the block pulses a resend request so that sources holding rejected work can present it again.

Top module: `irq_presenter`

## Requirements
- R1: After reset, intOut is low, the threshold is 0x00, the pending priority and the inter-processor level are 0xFF, and the pending source number is 0. An accept issued first returns 0x00000000.
- R2: Accept returns the presentation word on rdData, with rdValid high one cycle after the command. Bits 31:24 hold the threshold and bits 23:0 hold the pending source number, where 0 means nothing is pending.
- R3: A presented request with priority p is refused when p >= threshold, or when something is pending at a priority <= p. It is then rejected one cycle later on rejValid/rejSrc with its own number, and the slot is left unchanged.
- R4: A request that is not refused takes the slot, and intOut is high from the next cycle. If an externally sourced interrupt was pending, that interrupt's number is rejected in the same cycle.
- R5: Accept lowers intOut, moves the old pending priority into the threshold, clears the source number and sets the pending priority to 0xFF. The accepted source is not rejected.
- R6: Set-threshold (cmdOp=1, value in cmdData[7:0]) to a lower value clears the slot when something is pending and the new value <= the pending priority. It then lowers intOut and rejects the cleared external source.
- R7: Set-threshold to a higher value pulses resendPulse. It then injects an inter-processor interrupt if the request level is below the new threshold.
- R8: Set-request-level (cmdOp=2, value in cmdData[7:0]) below the threshold injects an inter-processor interrupt: source number 2, pending priority equal to the level, intOut high. This is skipped when something is pending at a priority <= the level.
- R9: An inter-processor interrupt that is displaced or cleared produces no reject strobe.
- R10: End-of-interrupt (cmdOp=3) loads cmdData[31:24] into the threshold and pulses resendPulse. It forwards cmdData[23:0] on eoiValid/eoiSrc unless that number is 0 or 2, and it then runs the inter-processor check against the new threshold.
- R11: reqReady is low while cmdValid is high. A request presented in that cycle is not taken into the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 accept, 1 set threshold, 2 set request level, 3 end-of-interrupt |
| cmdData | input | 32 | Command operand |
| reqValid | input | 1 | Source presents an interrupt |
| reqSrc | input | 24 | Presented source number (nonzero, not 2) |
| reqPrio | input | 8 | Presented priority |
| reqReady | output | 1 | Request is considered this cycle |
| intOut | output | 1 | Interrupt line to the processor |
| rdValid | output | 1 | Accept result valid |
| rdData | output | 32 | Presentation word returned by accept |
| rejValid | output | 1 | Reject strobe towards sources |
| rejSrc | output | 24 | Rejected source number |
| eoiValid | output | 1 | End-of-interrupt strobe towards sources |
| eoiSrc | output | 24 | End-of-interrupt source number |
| resendPulse | output | 1 | Request for sources to re-present |

## Verification
The hardest states to reach are those where the slot holds an inter-processor interrupt that is then displaced or cleared. The block must stay silent on the reject strobe there, while in the same kind of state with an external owner it must speak. The stimulus gets into that state in two ways: by relaxing the threshold so that a pending request level becomes eligible, and by sending an end-of-interrupt that re-runs the check. It then presents a more urgent external request over it. A command and a request issued in the same cycle check that the request is held off and leaves the slot alone.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  parameter int PRIO_W = 8;
  parameter int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_SET_CPPR = 2'd1,
    OP_SET_MFRR = 2'd2,
    OP_EOI      = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    CP_KEEP = 2'd0,
    CP_LOW  = 2'd1,
    CP_HIGH = 2'd2,
    CP_PEND = 2'd3
  } cppr_sel_e;

  typedef struct packed {
    cppr_sel_e cpprSel;
    logic      wrMfrr;
    logic      clrPend;
    logic      takeReq;
    logic      takeIpi;
    logic      doReject;
    logic      rejectReq;
    logic      doAccept;
    logic      doEoi;
    logic      doResend;
  } strobe_t;
endpackage

// File: rtl/irqp_ctrl.sv
module irqp_ctrl
  import irqp_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_NUM = 24'd2
) (
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [WORD_W-1:0] cmdData,
  input  logic              reqValid,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] mfrr,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic              xisrNz,
  input  logic              ownedExt,
  output strobe_t           st
);
  logic [PRIO_W-1:0] lowVal, highVal, ipiCp, ipiMf;
  logic [SRC_W-1:0]  eoiNum;
  logic              ipiEn;

  assign lowVal  = cmdData[PRIO_W-1:0];
  assign highVal = cmdData[WORD_W-1:SRC_W];
  assign eoiNum  = cmdData[SRC_W-1:0];

  always_comb begin
    st      = '0;
    ipiEn   = 1'b0;
    ipiCp   = cppr;
    ipiMf   = mfrr;
    if (cmdValid) begin
      case (cmd_op_e'(cmdOp))
        OP_ACCEPT: begin
          st.doAccept = 1'b1;
          st.cpprSel  = CP_PEND;
          st.clrPend  = 1'b1;
        end
        OP_SET_CPPR: begin
          st.cpprSel = CP_LOW;
          if (lowVal < cppr) begin
            if (xisrNz && (lowVal <= pendPrio)) begin
              st.clrPend  = 1'b1;
              st.doReject = ownedExt;
            end
          end else if (lowVal > cppr) begin
            st.doResend = 1'b1;
            ipiEn       = 1'b1;
            ipiCp       = lowVal;
          end
        end
        OP_SET_MFRR: begin
          st.wrMfrr = 1'b1;
          ipiEn     = 1'b1;
          ipiMf     = lowVal;
        end
        default: begin
          st.cpprSel  = CP_HIGH;
          st.doEoi    = (eoiNum != '0) && (eoiNum != IPI_NUM);
          st.doResend = 1'b1;
          ipiEn       = 1'b1;
          ipiCp       = highVal;
        end
      endcase
      if (ipiEn && (ipiMf < ipiCp) && !(xisrNz && (pendPrio <= ipiMf))) begin
        st.takeIpi  = 1'b1;
        st.doReject = xisrNz && ownedExt;
      end
    end else if (reqValid) begin
      if ((reqPrio >= cppr) || (xisrNz && (pendPrio <= reqPrio))) begin
        st.doReject  = 1'b1;
        st.rejectReq = 1'b1;
      end else begin
        st.takeReq  = 1'b1;
        st.doReject = xisrNz && ownedExt;
      end
    end
  end
endmodule

// File: rtl/irqp_datapath.sv
module irqp_datapath
  import irqp_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_NUM = 24'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [WORD_W-1:0] cmdData,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  output logic [PRIO_W-1:0] cppr,
  output logic [PRIO_W-1:0] mfrr,
  output logic [PRIO_W-1:0] pendPrio,
  output logic [SRC_W-1:0]  xisr,
  output logic              ownedExt,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              rejValid,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendPulse
);
  logic [PRIO_W-1:0] ipiPrio;
  assign ipiPrio = st.wrMfrr ? cmdData[PRIO_W-1:0] : mfrr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cppr        <= '0;
      mfrr        <= PRIO_NONE;
      pendPrio    <= PRIO_NONE;
      xisr        <= '0;
      ownedExt    <= 1'b0;
      rdValid     <= 1'b0;
      rdData      <= '0;
      rejValid    <= 1'b0;
      rejSrc      <= '0;
      eoiValid    <= 1'b0;
      eoiSrc      <= '0;
      resendPulse <= 1'b0;
    end else begin
      case (st.cpprSel)
        CP_LOW:  cppr <= cmdData[PRIO_W-1:0];
        CP_HIGH: cppr <= cmdData[WORD_W-1:SRC_W];
        CP_PEND: cppr <= pendPrio;
        default: ;
      endcase
      if (st.wrMfrr) mfrr <= cmdData[PRIO_W-1:0];
      if (st.clrPend) begin
        xisr     <= '0;
        pendPrio <= PRIO_NONE;
        ownedExt <= 1'b0;
      end else if (st.takeReq) begin
        xisr     <= reqSrc;
        pendPrio <= reqPrio;
        ownedExt <= 1'b1;
      end else if (st.takeIpi) begin
        xisr     <= IPI_NUM;
        pendPrio <= ipiPrio;
        ownedExt <= 1'b0;
      end
      rejValid    <= st.doReject;
      rejSrc      <= st.rejectReq ? reqSrc : xisr;
      rdValid     <= st.doAccept;
      rdData      <= {cppr, xisr};
      eoiValid    <= st.doEoi;
      eoiSrc      <= cmdData[SRC_W-1:0];
      resendPulse <= st.doResend;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irqp_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_NUM = 24'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [WORD_W-1:0] cmdData,
  input  logic              reqValid,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [PRIO_W-1:0] reqPrio,
  output logic              reqReady,
  output logic              intOut,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              rejValid,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              eoiValid,
  output logic [SRC_W-1:0]  eoiSrc,
  output logic              resendPulse
);
  strobe_t           st;
  logic [PRIO_W-1:0] cppr, mfrr, pendPrio;
  logic [SRC_W-1:0]  xisr;
  logic              ownedExt;

  assign reqReady = !cmdValid;
  assign intOut   = (xisr != '0);

  irqp_ctrl #(.IPI_NUM(IPI_NUM)) u_ctrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .reqValid(reqValid), .reqPrio(reqPrio),
    .cppr(cppr), .mfrr(mfrr), .pendPrio(pendPrio),
    .xisrNz(intOut), .ownedExt(ownedExt), .st(st)
  );

  irqp_datapath #(.IPI_NUM(IPI_NUM)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cmdData(cmdData),
    .reqSrc(reqSrc), .reqPrio(reqPrio),
    .cppr(cppr), .mfrr(mfrr), .pendPrio(pendPrio), .xisr(xisr),
    .ownedExt(ownedExt), .rdValid(rdValid), .rdData(rdData),
    .rejValid(rejValid), .rejSrc(rejSrc), .eoiValid(eoiValid),
    .eoiSrc(eoiSrc), .resendPulse(resendPulse)
  );
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker
  import irqp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [PRIO_W-1:0] cmdLow,
  input logic [PRIO_W-1:0] cmdHigh,
  input logic              reqValid,
  input logic              reqReady,
  input logic [SRC_W-1:0]  reqSrc,
  input logic [PRIO_W-1:0] reqPrio,
  input logic              intOut,
  input logic              rdValid,
  input logic              rejValid,
  input logic [SRC_W-1:0]  rejSrc,
  input logic [PRIO_W-1:0] cppr,
  input logic [SRC_W-1:0]  xisr
);
  a_r3_refuse_rejects: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cmdValid && (reqPrio >= cppr)) |=> (rejValid && (rejSrc == $past(reqSrc))));

  a_r4_take_raises: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cmdValid && (reqSrc != '0) && (reqPrio < cppr) && (xisr == '0))
      |=> (intOut && (xisr == $past(reqSrc)) && !rejValid));

  a_r5_accept_lowers: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == OP_ACCEPT)) |=> (!intOut && rdValid));

  a_r8_ipi_injects: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == OP_SET_MFRR) && (cmdLow < cppr) && (xisr == '0))
      |=> (intOut && (xisr == 24'd2)));

  a_r9_ipi_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == OP_SET_MFRR) && (xisr == 24'd2)) |=> !rejValid);

  a_r10_eoi_cppr: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == OP_EOI)) |=> (cppr == $past(cmdHigh)));

  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady);

  a_r11_no_take: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && reqValid && (cmdOp == OP_SET_MFRR) && (cmdLow >= cppr))
      |=> (xisr == $past(xisr)));
endmodule

bind irq_presenter irqp_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdLow(cmdData[7:0]), .cmdHigh(cmdData[31:24]),
  .reqValid(reqValid), .reqReady(reqReady), .reqSrc(reqSrc), .reqPrio(reqPrio),
  .intOut(intOut), .rdValid(rdValid), .rejValid(rejValid), .rejSrc(rejSrc),
  .cppr(cppr), .xisr(xisr)
);

// File: tb/tb_irq_presenter.sv
`timescale 1ns/1ps
module tb_irq_presenter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [31:0] cmdData = '0;
  logic        reqValid = 1'b0;
  logic [23:0] reqSrc = '0;
  logic [7:0]  reqPrio = '0;
  logic        reqReady, intOut, rdValid, rejValid, eoiValid, resendPulse;
  logic [31:0] rdData;
  logic [23:0] rejSrc, eoiSrc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  irq_presenter dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqPrio(reqPrio), .reqReady(reqReady),
    .intOut(intOut), .rdValid(rdValid), .rdData(rdData), .rejValid(rejValid),
    .rejSrc(rejSrc), .eoiValid(eoiValid), .eoiSrc(eoiSrc), .resendPulse(resendPulse)
  );

  // kinds: 0 reject, 1 accept word, 2 end-of-interrupt, 3 resend
  task automatic push(input int kind, input logic [31:0] val, input string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic popChk(input int kind, input logic [31:0] val);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, $sformatf("unexpected event kind %0d", kind), val, 32'h0);
    end else begin
      e = q.pop_front();
      check((e.kind == kind) && (e.val == val), e.tag, {kind[3:0], val[27:0]}, {e.kind[3:0], e.val[27:0]});
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rejValid)    popChk(0, {8'h0, rejSrc});
      if (rdValid)     popChk(1, rdData);
      if (eoiValid)    popChk(2, {8'h0, eoiSrc});
      if (resendPulse) popChk(3, 32'h0);
    end
  end

  task automatic drive(input bit cv, input logic [1:0] op, input logic [31:0] d,
                       input bit rv, input logic [23:0] s, input logic [7:0] p);
    @(negedge clk);
    cmdValid = cv; cmdOp = op; cmdData = d;
    reqValid = rv; reqSrc = s; reqPrio = p;
    #1;
    if (cv && rv) check(reqReady == 1'b0, "R11 reqReady during command", {31'h0, reqReady}, 32'h0);
    @(negedge clk);
    cmdValid = 1'b0; reqValid = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] d);
    drive(1'b1, op, d, 1'b0, 24'h0, 8'h0);
  endtask

  task automatic req(input logic [23:0] s, input logic [7:0] p);
    drive(1'b0, 2'd0, 32'h0, 1'b1, s, p);
  endtask

  task automatic chkInt(input bit exp, input string tag);
    check(intOut == exp, tag, {31'h0, intOut}, {31'h0, exp});
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkInt(1'b0, "R1 intOut after reset");
    push(1, 32'h0000_0000, "R1 R2 accept after reset");
    cmd(2'd0, 32'h0);                               // threshold -> 0xFF
    req(24'h100, 8'h05);
    chkInt(1'b1, "R4 request taken");
    push(0, 32'h100 | 32'h1, "R3 equal priority refused");
    req(24'h101, 8'h05);
    push(0, 32'h100, "R4 displaced source rejected");
    req(24'h102, 8'h03);
    push(1, 32'hFF00_0102, "R2 R5 accept word");
    cmd(2'd0, 32'h0);
    chkInt(1'b0, "R5 accept lowers intOut");
    push(0, 32'h103, "R3 priority at threshold refused");
    req(24'h103, 8'h03);
    push(2, 32'h102, "R10 eoi source forwarded");
    push(3, 32'h0, "R10 eoi resend");
    cmd(2'd3, 32'hFF00_0102);
    req(24'h104, 8'h10);
    cmd(2'd2, 32'h20);                              // pending 0x10 <= 0x20: skip
    chkInt(1'b1, "R8 skip keeps external pending");
    push(0, 32'h104, "R8 ipi displaces external");
    cmd(2'd2, 32'h08);
    push(1, 32'hFF00_0002, "R8 ipi number 2 pending");
    cmd(2'd0, 32'h0);                               // threshold -> 0x08
    push(3, 32'h0, "R7 resend on relaxed threshold");
    cmd(2'd1, 32'h30);
    chkInt(1'b1, "R7 ipi injected on relaxed threshold");
    req(24'h105, 8'h04);                            // displaces ipi silently (R9)
    chkInt(1'b1, "R9 external over ipi");
    push(0, 32'h105, "R6 cleared source rejected");
    cmd(2'd1, 32'h04);
    chkInt(1'b0, "R6 clear lowers intOut");
    push(1, 32'h0400_0000, "R6 slot cleared");
    cmd(2'd0, 32'h0);                               // threshold -> 0xFF
    cmd(2'd1, 32'h40);                              // nothing pending: silent
    push(3, 32'h0, "R10 resend on ipi eoi");
    cmd(2'd3, 32'h8000_0002);                       // no eoi strobe for 2 (R9 R10)
    chkInt(1'b1, "R10 ipi recheck after eoi");
    drive(1'b1, 2'd2, 32'hFF, 1'b1, 24'h106, 8'h01);
    push(1, 32'h8000_0002, "R11 request during command not taken");
    cmd(2'd0, 32'h0);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "missing expected events", q.size(), 32'h0);
    finishRun();
  end
endmodule